// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen general registers of a processor core together with the shadow copies that exist for each exception mode. It also keeps the status word and one saved copy of the status word for each exception mode. The low five bits of the status word select the mode. That mode decides which physical storage each visible register index R0–R15 refers to. Reads go through that mapping combinationally. A mode change therefore switches banks without moving any data.

The fast-interrupt mode (mode value 0x11) has private copies of R8 through R14. The interrupt (0x12), supervisor (0x13), abort (0x17) and undefined (0x1B) modes each have private copies of R13 and R14 only. Every other mode value, including user and system, uses the shared base registers. R15 is never shadowed.

The saved-status port reaches the saved word of whichever exception mode is current. A restore request copies that word into the status word. If the current mode has no saved word, the request is refused and an error pulse is raised.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every visible register reads 0 in every mode, the status word reads 0x000000D3, the mode output reads 0x13 and the restore error is low.
- R2: For any mode value other than 0x11, 0x12, 0x13, 0x17 and 0x1B (for example 0x10, 0x1F or 0x05), all sixteen indices address the same shared base registers.
- R3: In mode 0x11, indices 8 to 14 address a private seven-entry bank, and indices 0 to 7 and 15 address the base registers.
- R4: In modes 0x12, 0x13, 0x17 and 0x1B, indices 13 and 14 address a two-entry bank private to that mode, and indices 0 to 12 and 15 address the base registers.
- R5: A register write lands in the storage selected by the mode that is current in the write cycle, including when the status word changes in the same cycle. From the next cycle the written value is visible on both read ports, which read independently and combinationally.
- R6: A status write appears on the status output in the next cycle. From that same cycle the reads follow the new mode. The contents of every bank are kept across mode changes.
- R7: A status write that keeps bits 4:0 unchanged updates the other bits and leaves every register read unchanged.
- R8: Each of the five exception modes has its own saved-status word. A saved write stores into the current mode's word, and the saved read returns the current mode's word. In any other mode a saved write is ignored and the saved read returns 0.
- R9: A restore request in an exception mode loads that mode's saved word into the status word on the next cycle. The banks rebind to the restored mode, and the error stays low.
- R10: A restore request in a mode without a saved word leaves the status word unchanged and drives the restore error high for exactly the following cycle.
- R11: If a restore request and a status write occur in the same cycle, the restore takes effect and the status write is dropped.
- R12: Index 15 refers to one physical register in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | XLEN | Read port A data, combinational |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | XLEN | Read port B data, combinational |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | XLEN | Register write data |
| stat_we | input | 1 | Status word write enable |
| stat_wdata | input | XLEN | Status word write data |
| stat_q | output | XLEN | Current status word |
| cur_mode | output | 5 | Current mode (status bits 4:0) |
| saved_we | input | 1 | Saved-status write enable (current mode's word) |
| saved_wdata | input | XLEN | Saved-status write data |
| saved_rdata | output | XLEN | Current mode's saved status, 0 outside exception modes |
| restore_req | input | 1 | Copy current mode's saved status into the status word |
| restore_err | output | 1 | One-cycle pulse after a refused restore |

## Verification
Register reads are combinational, so a read index applied after a write, status write or restore has settled must show the new value at once. Every write-type operation, whether register, status, saved or restore, is visible one rising edge after it is applied. The restore error is high only in the cycle after the refused request. The bench drives inputs one time unit after a rising edge and samples outputs shortly afterwards, well before the next edge. It checks the error pulse both one and two edges after the request.

// File: rtl/bank_pkg.sv
package bank_pkg;

    localparam int MODE_W    = 5;
    localparam int VIDX_W    = 4;
    localparam int NUM_VIS   = 16;

    localparam logic [MODE_W-1:0] MODE_FAST = 5'h11;
    localparam logic [MODE_W-1:0] MODE_INTR = 5'h12;
    localparam logic [MODE_W-1:0] MODE_SUPV = 5'h13;
    localparam logic [MODE_W-1:0] MODE_ABRT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_UNDF = 5'h1B;

    // fast-interrupt bank covers indices FAST_LO..FAST_LO+FAST_CNT-1
    localparam int FAST_LO   = 8;
    localparam int FAST_CNT  = 7;
    // pair bank covers PAIR_LO..PAIR_LO+PAIR_CNT-1 for each of PAIR_MODES modes
    localparam int PAIR_LO   = 13;
    localparam int PAIR_CNT  = 2;
    localparam int PAIR_MODES = 4;
    localparam int NUM_SAVED = PAIR_MODES + 1;

    localparam int FAST_BASE = NUM_VIS;
    localparam int PAIR_BASE = FAST_BASE + FAST_CNT;
    localparam int PHYS_CNT  = PAIR_BASE + PAIR_MODES * PAIR_CNT;
    localparam int PHYS_W    = $clog2(PHYS_CNT);
    localparam int SLOT_W    = $clog2(NUM_SAVED);

    localparam logic [31:0] STATUS_RESET = 32'h0000_00D3;

    typedef enum logic [2:0] {
        BK_NONE = 3'd0,
        BK_FAST = 3'd1,
        BK_INTR = 3'd2,
        BK_SUPV = 3'd3,
        BK_ABRT = 3'd4,
        BK_UNDF = 3'd5
    } bank_sel_e;

    function automatic bank_sel_e mode_to_bank(input logic [MODE_W-1:0] m);
        case (m)
            MODE_FAST: return BK_FAST;
            MODE_INTR: return BK_INTR;
            MODE_SUPV: return BK_SUPV;
            MODE_ABRT: return BK_ABRT;
            MODE_UNDF: return BK_UNDF;
            default:   return BK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/bank_index_map.sv
module bank_index_map
    import bank_pkg::*;
(
    input  bank_sel_e                 sel,
    input  logic [VIDX_W-1:0]         vidx,
    output logic [PHYS_W-1:0]         pidx
);

    int v;
    int k;

    always_comb begin
        v    = int'(vidx);
        k    = int'(sel) - int'(BK_INTR);
        pidx = PHYS_W'(v);
        if (sel == BK_FAST && v >= FAST_LO && v < FAST_LO + FAST_CNT) begin
            pidx = PHYS_W'(FAST_BASE + v - FAST_LO);
        end else if (sel != BK_NONE && sel != BK_FAST &&
                     v >= PAIR_LO && v < PAIR_LO + PAIR_CNT) begin
            pidx = PHYS_W'(PAIR_BASE + k * PAIR_CNT + v - PAIR_LO);
        end
    end

endmodule

// File: rtl/status_unit.sv
module status_unit
    import bank_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_we,
    input  logic [XLEN-1:0]  stat_wdata,
    input  logic             saved_we,
    input  logic [XLEN-1:0]  saved_wdata,
    input  logic             restore_req,
    output logic [XLEN-1:0]  stat_q,
    output bank_sel_e        sel,
    output logic [XLEN-1:0]  saved_rdata,
    output logic             restore_err
);

    typedef struct packed {
        logic [XLEN-1:0]                stat;
        logic [NUM_SAVED-1:0][XLEN-1:0] saved;
        logic                           err;
    } st_t;

    st_t st_d, st_q;
    logic              has_saved;
    logic [SLOT_W-1:0] slot;

    always_comb begin
        sel       = mode_to_bank(st_q.stat[MODE_W-1:0]);
        has_saved = (sel != BK_NONE);
        slot      = has_saved ? SLOT_W'(int'(sel) - 1) : '0;
        saved_rdata = has_saved ? st_q.saved[slot] : '0;

        st_d     = st_q;
        st_d.err = 1'b0;
        if (restore_req) begin
            if (has_saved) st_d.stat = st_q.saved[slot];
            else           st_d.err  = 1'b1;
        end else if (stat_we) begin
            st_d.stat = stat_wdata;
        end
        if (saved_we && has_saved) begin
            st_d.saved[slot] = saved_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stat  <= XLEN'(STATUS_RESET);
            st_q.saved <= '0;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_q      = st_q.stat;
    assign restore_err = st_q.err;

    // R10
    bad_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && sel == BK_NONE) |=> (restore_err && $stable(stat_q)));

    // R9
    good_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && sel != BK_NONE) |=> (stat_q == $past(saved_rdata) && !restore_err));

    // R6
    stat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && !restore_req) |=> (stat_q == $past(stat_wdata)));

    // R8
    saved_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (saved_we && sel == BK_NONE) |=> $stable(st_q.saved));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bank_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         rd_a_idx,
    output logic [XLEN-1:0]    rd_a_data,
    input  logic [3:0]         rd_b_idx,
    output logic [XLEN-1:0]    rd_b_data,
    input  logic               wr_en,
    input  logic [3:0]         wr_idx,
    input  logic [XLEN-1:0]    wr_data,
    input  logic               stat_we,
    input  logic [XLEN-1:0]    stat_wdata,
    output logic [XLEN-1:0]    stat_q,
    output logic [4:0]         cur_mode,
    input  logic               saved_we,
    input  logic [XLEN-1:0]    saved_wdata,
    output logic [XLEN-1:0]    saved_rdata,
    input  logic               restore_req,
    output logic               restore_err
);

    localparam int NUM_RD = 2;

    typedef struct packed {
        logic [PHYS_CNT-1:0][XLEN-1:0] regs;
    } rf_t;

    rf_t rf_d, rf_q;
    bank_sel_e sel;

    logic [NUM_RD-1:0][VIDX_W-1:0] rd_vidx;
    logic [NUM_RD-1:0][PHYS_W-1:0] rd_pidx;
    logic [NUM_RD-1:0][XLEN-1:0]   rd_val;
    logic [PHYS_W-1:0]             wr_pidx;

    status_unit #(.XLEN(XLEN)) i_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_we     (stat_we),
        .stat_wdata  (stat_wdata),
        .saved_we    (saved_we),
        .saved_wdata (saved_wdata),
        .restore_req (restore_req),
        .stat_q      (stat_q),
        .sel         (sel),
        .saved_rdata (saved_rdata),
        .restore_err (restore_err)
    );

    assign rd_vidx[0] = rd_a_idx;
    assign rd_vidx[1] = rd_b_idx;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        bank_index_map i_map (
            .sel  (sel),
            .vidx (rd_vidx[p]),
            .pidx (rd_pidx[p])
        );
        assign rd_val[p] = rf_q.regs[rd_pidx[p]];
    end

    bank_index_map i_wmap (
        .sel  (sel),
        .vidx (wr_idx),
        .pidx (wr_pidx)
    );

    always_comb begin
        rf_d = rf_q;
        if (wr_en) rf_d.regs[wr_pidx] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign rd_a_data = rd_val[0];
    assign rd_b_data = rd_val[1];
    assign cur_mode  = stat_q[MODE_W-1:0];

    // R5
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !stat_we && !restore_req) |=>
        (rd_a_idx != $past(wr_idx) || rd_a_data == $past(wr_data)));

endmodule

// File: tb/test_banked_regfile.sv
module test_banked_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic wr_en = 1'b0, stat_we = 1'b0, saved_we = 1'b0, restore_req = 1'b0;
    logic [XLEN-1:0] stat_wdata = '0, saved_wdata = '0, stat_q, saved_rdata;
    logic [4:0] cur_mode;
    logic restore_err;

    int n_chk = 0;
    int n_bad = 0;
    logic [XLEN-1:0] base [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_regfile #(.XLEN(XLEN)) i_banked_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_q(stat_q),
        .cur_mode(cur_mode),
        .saved_we(saved_we), .saved_wdata(saved_wdata), .saved_rdata(saved_rdata),
        .restore_req(restore_req), .restore_err(restore_err)
    );

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input int idx, input logic [XLEN-1:0] d);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic set_stat(input logic [XLEN-1:0] v);
        stat_we = 1'b1; stat_wdata = v;
        tick();
        stat_we = 1'b0;
    endtask

    task automatic set_saved(input logic [XLEN-1:0] v);
        saved_we = 1'b1; saved_wdata = v;
        tick();
        saved_we = 1'b0;
    endtask

    task automatic chk_rd(input string tag, input int idx, input logic [XLEN-1:0] exp);
        rd_a_idx = 4'(idx); rd_b_idx = 4'(idx);
        #1;
        check($sformatf("%s A r%0d", tag, idx), rd_a_data, exp);
        check($sformatf("%s B r%0d", tag, idx), rd_b_data, exp);
    endtask

    task automatic t_reset();
        check("R1 status", stat_q, 32'h0000_00D3);
        check("R1 mode", 32'(cur_mode), 32'h13);
        check("R1 err", 32'(restore_err), 0);
        for (int i = 0; i < 16; i++) chk_rd("R1", i, 0);
        set_stat(32'h10);
        for (int i = 0; i < 16; i++) chk_rd("R1 user", i, 0);
    endtask

    task automatic t_base_modes();
        set_stat(32'h10);
        for (int i = 0; i < 16; i++) begin
            base[i] = 32'h0000_0100 + 32'(i);
            wr_reg(i, base[i]);
        end
        for (int i = 0; i < 16; i++) chk_rd("R2 user", i, base[i]);
        set_stat(32'h1F);
        for (int i = 0; i < 16; i++) chk_rd("R2 system", i, base[i]);
        set_stat(32'h05);
        for (int i = 0; i < 16; i++) chk_rd("R2 other", i, base[i]);
    endtask

    task automatic t_fast();
        set_stat(32'h11);
        for (int i = 0; i < 8; i++) chk_rd("R3 shared", i, base[i]);
        for (int i = 8; i < 15; i++) chk_rd("R3 private fresh", i, 0);
        chk_rd("R12 fast", 15, base[15]);
        for (int i = 8; i < 15; i++) wr_reg(i, 32'h0000_0F00 + 32'(i));
        wr_reg(15, 32'h0000_0ABC);
        base[15] = 32'h0000_0ABC;
        set_stat(32'h10);
        for (int i = 8; i < 15; i++) chk_rd("R3 base kept", i, base[i]);
        chk_rd("R12 user", 15, base[15]);
        set_stat(32'h11);
        for (int i = 8; i < 15; i++) chk_rd("R6 fast kept", i, 32'h0000_0F00 + 32'(i));
    endtask

    task automatic t_pairs();
        logic [4:0] modes [4] = '{5'h12, 5'h13, 5'h17, 5'h1B};
        for (int m = 0; m < 4; m++) begin
            set_stat(32'(modes[m]));
            chk_rd("R4 shared r12", 12, base[12]);
            chk_rd("R4 shared r8", 8, base[8]);
            wr_reg(13, {24'h0, 3'b0, modes[m]} << 8 | 32'hD);
            wr_reg(14, {24'h0, 3'b0, modes[m]} << 8 | 32'hE);
        end
        for (int m = 0; m < 4; m++) begin
            set_stat(32'(modes[m]));
            chk_rd("R4 private r13", 13, {24'h0, 3'b0, modes[m]} << 8 | 32'hD);
            chk_rd("R4 private r14", 14, {24'h0, 3'b0, modes[m]} << 8 | 32'hE);
            chk_rd("R12 pair", 15, base[15]);
        end
        set_stat(32'h10);
        chk_rd("R4 base r13", 13, base[13]);
        chk_rd("R4 base r14", 14, base[14]);
    endtask

    task automatic t_write_vs_mode();
        // write in user mode while switching to interrupt mode: lands in base
        wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'hCAFE_0013;
        stat_we = 1'b1; stat_wdata = 32'h12;
        tick();
        wr_en = 1'b0; stat_we = 1'b0;
        base[13] = 32'hCAFE_0013;
        check("R6 mode", 32'(cur_mode), 32'h12);
        chk_rd("R5 irq bank untouched", 13, 32'h0000_120D);
        set_stat(32'h10);
        chk_rd("R5 base got write", 13, base[13]);
        rd_a_idx = 4'd3; rd_b_idx = 4'd13;
        #1;
        check("R5 dual A", rd_a_data, base[3]);
        check("R5 dual B", rd_b_data, base[13]);
    endtask

    task automatic t_same_mode();
        set_stat(32'h12);
        set_stat(32'h92);
        check("R7 status", stat_q, 32'h92);
        chk_rd("R7 r13", 13, 32'h0000_120D);
        chk_rd("R7 r8", 8, base[8]);
    endtask

    task automatic t_saved();
        set_saved(32'h1234_0010);
        check("R8 irq saved", saved_rdata, 32'h1234_0010);
        set_stat(32'h13);
        check("R8 svc fresh", saved_rdata, 0);
        set_saved(32'h5555_0011);
        check("R8 svc saved", saved_rdata, 32'h5555_0011);
        set_stat(32'h10);
        check("R8 user read", saved_rdata, 0);
        set_saved(32'hDEAD_BEEF);
        check("R8 user ignored", saved_rdata, 0);
        set_stat(32'h12);
        check("R8 irq kept", saved_rdata, 32'h1234_0010);
        set_stat(32'h13);
        check("R8 svc kept", saved_rdata, 32'h5555_0011);
        set_stat(32'h17);
        check("R8 abt untouched", saved_rdata, 0);
    endtask

    task automatic t_restore();
        set_stat(32'h13);
        restore_req = 1'b1;
        tick();
        restore_req = 1'b0;
        check("R9 status", stat_q, 32'h5555_0011);
        check("R9 mode", 32'(cur_mode), 32'h11);
        check("R9 err", 32'(restore_err), 0);
        chk_rd("R9 fast bank", 8, 32'h0000_0F08);
    endtask

    task automatic t_bad_restore();
        set_stat(32'h4000_0010);
        restore_req = 1'b1;
        tick();
        restore_req = 1'b0;
        check("R10 status kept", stat_q, 32'h4000_0010);
        check("R10 err high", 32'(restore_err), 1);
        tick();
        check("R10 err single", 32'(restore_err), 0);
    endtask

    task automatic t_priority();
        set_stat(32'h12);
        restore_req = 1'b1; stat_we = 1'b1; stat_wdata = 32'h1B;
        tick();
        restore_req = 1'b0; stat_we = 1'b0;
        check("R11 restore wins", stat_q, 32'h1234_0010);
        check("R11 mode", 32'(cur_mode), 32'h10);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        t_reset();
        t_base_modes();
        t_fast();
        t_pairs();
        t_write_vs_mode();
        t_same_mode();
        t_saved();
        t_restore();
        t_bad_restore();
        t_priority();
        finish_run();
    end

endmodule